// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block sets every entry of a switch's connection memory to one common value, so that software can bring the memory to a known state without writing each location. The value comes from a 5-bit pattern held in a field of the interface-mode register. The pattern goes into the top five bits of each 16-bit entry, and the other eleven bits are written as zero.

A fill needs two register bits at once: a fill-mode bit in the control register and a fill-enable bit in the mode register. When both are high, the block captures the pattern. It then steps through the addresses from 0 upward and writes one entry each time the switch grants it an internal access slot. When the fill finishes, the block raises a one-cycle strobe that tells the mode register to clear its enable bit.

Processor writes pass straight to the memory port while the block is idle and are suppressed while it is busy. Clearing the fill-mode bit during a fill stops the fill at once, and the block then issues the same clear strobe.

Top module: `cm_block_fill`

## Requirements
- R1: While reset is asserted, `busy`, `en_clr` and `cm_we` are low (with `cpu_we` low).
- R2: A fill starts only when `mode_fill` and `fill_en` are both high at a clock edge while idle. With only one of them high, `busy` stays low and processor writes reach the memory port.
- R3: A fill writes addresses 0, 1, …, DEPTH-1 in ascending order. It makes exactly one write in each cycle where `slot_en` is high and no write in a cycle where `slot_en` is low.
- R4: Each fill write carries data {pattern, 11'b0}. Bits 15:11 hold the 5-bit pattern and bits 10:0 are zero.
- R5: `en_clr` is high for exactly one cycle. That cycle is the one right after the last fill write, or the one right after an abort.
- R6: When idle, `cm_we`, `cm_addr` and `cm_wdata` follow `cpu_we`, `cpu_addr` and `cpu_wdata`. While `busy` is high, a processor write never reaches the port; the fill's own write takes the port in the same cycle.
- R7: If `mode_fill` is low during a fill, no write is made in that cycle or later, and `en_clr` follows in the next cycle.
- R8: `busy` rises in the cycle after the start condition is seen. It stays high through the `en_clr` cycle and is low in the cycle after that.
- R9: The pattern is captured when the fill starts. Changes to `fill_pat` during the fill do not alter the data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Internal access slot granted to the fill this cycle |
| mode_fill | input | 1 | Fill-mode bit from the control register |
| fill_en | input | 1 | Fill-enable bit from the mode register |
| fill_pat | input | 5 | Pattern field from the mode register |
| cpu_we | input | 1 | Processor write request to the connection memory |
| cpu_addr | input | AW | Processor write address |
| cpu_wdata | input | 16 | Processor write data |
| cm_we | output | 1 | Connection memory write enable |
| cm_addr | output | AW | Connection memory write address |
| cm_wdata | output | 16 | Connection memory write data |
| en_clr | output | 1 | One-cycle strobe that clears the fill-enable bit |
| busy | output | 1 | Fill in progress |

## Verification
A processor write request and a fill write can fall in the same cycle. The bench holds `cpu_we` high with data whose low eleven bits are nonzero for every cycle of each fill, while `slot_en` is pulsed at several spacings. In slot cycles, the port must show exactly the expected fill address and {pattern, 11'b0}. In non-slot cycles and in the strobe cycle, `cm_we` must be low. A leaked processor write would therefore show up either as a wrong address or data, or as a write where none is expected.

// File: rtl/cm_block_fill.sv
module cm_block_fill #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  parameter int PW    = 5,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_en,
  input  logic          mode_fill,
  input  logic          fill_en,
  input  logic [PW-1:0] fill_pat,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cm_we,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_wdata,
  output logic          en_clr,
  output logic          busy
);

  localparam int ZW = DW - PW;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] pat_q;

  wire arm     = mode_fill & fill_en;
  wire fill_wr = (st == S_FILL) & slot_en & mode_fill;
  wire last    = addr_q == AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      pat_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (arm) begin
          st     <= S_FILL;
          addr_q <= '0;
          pat_q  <= fill_pat;
        end
        S_FILL: if (!mode_fill) st <= S_DONE;
          else if (slot_en) begin
            addr_q <= addr_q + AW'(1);
            if (last) st <= S_DONE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = st != S_IDLE;
  assign en_clr   = st == S_DONE;
  assign cm_we    = busy ? fill_wr : cpu_we;
  assign cm_addr  = busy ? addr_q  : cpu_addr;
  assign cm_wdata = busy ? {pat_q, {ZW{1'b0}}} : cpu_wdata;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !busy && !en_clr); // R1
  AST_ARM_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(mode_fill && fill_en)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) fill_wr |=> (st != S_FILL) || (addr_q == $past(addr_q) + AW'(1))); // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) busy && cm_we |-> cm_wdata[ZW-1:0] == '0); // R4
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) en_clr |=> !en_clr && !busy); // R5
  AST_CPU_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) busy && cpu_we && !slot_en |-> !cm_we); // R6
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n) busy && !mode_fill |-> !cm_we); // R7
  AST_BUSY_UNTIL_CLR: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(en_clr)); // R8

endmodule

// File: tb/cm_block_fill_tb_top.sv
module cm_block_fill_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, slot_en = 0, mode_fill = 0, fill_en = 0, cpu_we = 0;
  logic [4:0]    fill_pat  = '0;
  logic [AW-1:0] cpu_addr  = '0;
  logic [15:0]   cpu_wdata = '0;
  logic          cm_we, en_clr, busy;
  logic [AW-1:0] cm_addr;
  logic [15:0]   cm_wdata;

  int checks = 0, errors = 0;

  cm_block_fill #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .mode_fill(mode_fill), .fill_en(fill_en),
    .fill_pat(fill_pat), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .en_clr(en_clr), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {pattern, slot spacing, abort after N writes (FF = none)}
  localparam logic [15:0] VEC [5] = '{
    {5'h1F, 3'd1, 8'hFF}, {5'h0A, 3'd2, 8'hFF}, {5'h15, 3'd3, 8'hFF},
    {5'h00, 3'd1, 8'd5},  {5'h11, 3'd2, 8'd0}
  };

  task automatic run_fill(input logic [4:0] pat, input int gap, input logic [7:0] ab);
    int  wr = 0;
    bit  pend = 0, done = 0, exp_we;
    int  exp_n = (ab == 8'hFF) ? DEPTH : int'(ab);
    @(negedge clk);
    mode_fill = 1; fill_en = 1; fill_pat = pat; slot_en = 0; cpu_we = 0;
    #1 chk(busy == 0, "R8 idle before start", 32'(busy), 0);
    for (int c = 0; c < 4 * DEPTH && !done; c++) begin
      @(negedge clk);
      slot_en = (c % gap) == 0;
      fill_pat = ~pat;
      cpu_we = 1; cpu_wdata = 16'h07FF; cpu_addr = AW'(c + 7);
      if (ab != 8'hFF && wr == int'(ab) && !pend) mode_fill = 0;
      #1;
      chk(en_clr == pend, "R5 strobe timing", 32'(en_clr), 32'(pend));
      if (pend) begin
        done = 1;
        chk(wr == exp_n, "R3 write count", 32'(wr), 32'(exp_n));
        chk(cm_we == 0, "R6 processor blocked in strobe cycle", 32'(cm_we), 0);
        chk(busy == 1, "R8 busy in strobe cycle", 32'(busy), 1);
      end else begin
        chk(busy == 1, "R8 busy during fill", 32'(busy), 1);
        exp_we = slot_en && mode_fill;
        if (!mode_fill) chk(cm_we == 0, "R7 no write after abort", 32'(cm_we), 0);
        else chk(cm_we == exp_we, "R6 write gating by slot", 32'(cm_we), 32'(exp_we));
        if (exp_we) begin
          chk(cm_addr == AW'(wr), "R3 address order", 32'(cm_addr), 32'(wr));
          chk(cm_wdata == {pat, 11'b0}, "R4 R9 fill data", 32'(cm_wdata), 32'({pat, 11'b0}));
          wr++;
          if (wr == DEPTH) pend = 1;
        end
        if (!mode_fill) pend = 1;
      end
    end
    if (!done) chk(0, "R5 fill never completed", 0, 1);
    @(negedge clk);
    fill_en = 0; mode_fill = 0; slot_en = 0; cpu_we = 0;
    #1 chk(busy == 0 && en_clr == 0, "R8 busy low after strobe", 32'(busy), 0);
  endtask

  task automatic one_bit_only(input bit m, input bit e, input string tag);
    @(negedge clk);
    mode_fill = m; fill_en = e;
    repeat (3) @(negedge clk);
    cpu_we = 1; cpu_addr = AW'(9); cpu_wdata = 16'h1234;
    #1;
    chk(busy == 0, {tag, " no start with one bit"}, 32'(busy), 0);
    chk(cm_we == 1 && cm_addr == AW'(9) && cm_wdata == 16'h1234, "R6 processor write passes when idle",
        32'(cm_wdata), 32'h1234);
    @(negedge clk);
    mode_fill = 0; fill_en = 0; cpu_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy in reset", 32'(busy), 0);
    chk(en_clr == 0, "R1 strobe in reset", 32'(en_clr), 0);
    chk(cm_we == 0, "R1 write enable in reset", 32'(cm_we), 0);
    rst_n = 1;
    for (int i = 0; i < 5; i++)
      run_fill(VEC[i][15:11], int'(VEC[i][10:8]), VEC[i][7:0]);
    one_bit_only(1, 0, "R2 mode only");
    one_bit_only(0, 1, "R2 enable only");
    run_fill(5'h07, 1, 8'hFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule